// File: doc/BRIEF.md
# Prescaled Auto-Reload Up-Counter with Update Events

This block is a small memory-mapped timer. A programmable divider turns the input clock into count ticks, and a 16-bit counter advances on each tick. When the counter is at the reload limit on a tick, it goes back to zero and raises an update event. Each update event sets a sticky status flag. Through two enable bits, the flag drives a level interrupt line and a one-cycle DMA request.

Software sets up the timer through a simple synchronous register port. It writes the divider and the limit, then enables counting. It can also force an update, which restarts the counter and the divider and loads the pending divider value. A source-select bit keeps forced updates from touching the flag and the DMA line. The counter read word also carries a copy of the status flag in its top bit, so one read returns both the count and the pending state.

Top module: `updtmr`

## Requirements
- R1: After reset every register reads 0 and both irq_o and dma_o are low.
- R2: With divider value P active and limit A, counting updates occur every (A+1)*(P+1) clock cycles. The counter steps 0..A and then returns to 0 on the tick after it reads A. The first update comes (A+1)*(P+1) cycles after the enable write.
- R3: A divider value written at offset 0x28 is held pending. It becomes active only at the next update event, so the period already running keeps the old division.
- R4: While control bit 0 (count enable, offset 0x00) is 0, the counter and the divider hold their values.
- R5: Writing 1 to bit 0 at offset 0x14 forces an update. The counter and the divider go to 0 and the pending divider becomes active. The bit is never stored, and offset 0x14 always reads 0.
- R6: Status bit 0 (offset 0x10) is set by every update that is allowed to signal. Writing 0 to it clears it. Writing 1 to it has no effect.
- R7: irq_o is high exactly when the status flag and interrupt-enable bit 0 (offset 0x0C) are both set. It follows a write to either one from the cycle after that write.
- R8: A read at offset 0x24 returns the count in bits 15:0 and a copy of the status flag in bit 31.
- R9: A new limit written at offset 0x2C applies at once, with no pending copy.
- R10: When control bit 2 is 1, a forced update neither sets the flag nor pulses DMA. Counter wraps still do both.
- R11: dma_o pulses for one cycle on each update that is allowed to signal, but only when bit 8 at offset 0x0C is set.
- R12: Control bits 0 and 2, enable bits 0 and 8, and the 16-bit divider and limit all read back as written. Read data appears on the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid one cycle after the request |
| irq_o | output | 1 | Level interrupt request |
| dma_o | output | 1 | One-cycle DMA request pulse |

## Verification
The bench sweeps every combination of small divider and limit values and counts the cycles to the first update. An off-by-one in the divider compare or the wrap compare would show up there as a period that is too long or too short. It loads a new divider without a forced update and times two periods in a row. A design without the pending copy would stretch the first period, and one that never loads the copy would keep the second period short. It also stops the counter and reads it twice to catch drift, and forces updates under both source-select settings. A design that ignores the select bit would then raise the flag or a DMA pulse when it should not.

// File: rtl/updtmr_pkg.sv
package updtmr_pkg;

  localparam int OFS_CTL = 'h00;
  localparam int OFS_IEN = 'h0C;
  localparam int OFS_STS = 'h10;
  localparam int OFS_EVG = 'h14;
  localparam int OFS_CNT = 'h24;
  localparam int OFS_PSC = 'h28;
  localparam int OFS_ARL = 'h2C;

  localparam int B_CEN = 0;
  localparam int B_SRC = 2;
  localparam int B_UIE = 0;
  localparam int B_UDE = 8;
  localparam int B_UIF = 0;
  localparam int B_FRC = 0;

  typedef struct packed {
    logic cen;
    logic src_wrap_only;
    logic uie;
    logic ude;
  } tmr_cfg_t;

endpackage

// File: rtl/updtmr_regs.sv
module updtmr_regs
  import updtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              uif,
  output tmr_cfg_t          cfg_q,
  output tmr_cfg_t          cfg_d,
  output logic [PSC_W-1:0]  psc_pend,
  output logic [CNT_W-1:0]  arl,
  output logic              force_upd,
  output logic              sts_clr,
  output logic [DATA_W-1:0] rdata
);

  logic wr_ctl, wr_ien, wr_sts, wr_evg, wr_psc, wr_arl, rd_req;
  logic [DATA_W-1:0] rd_val;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;

  function automatic logic hit(input int ofs);
    return bus_sel && (bus_addr == ADDR_W'(ofs));
  endfunction

  assign wr_ctl = hit(OFS_CTL) && bus_wr;
  assign wr_ien = hit(OFS_IEN) && bus_wr;
  assign wr_sts = hit(OFS_STS) && bus_wr;
  assign wr_evg = hit(OFS_EVG) && bus_wr;
  assign wr_psc = hit(OFS_PSC) && bus_wr;
  assign wr_arl = hit(OFS_ARL) && bus_wr;
  assign rd_req = bus_sel && !bus_wr;

  assign force_upd = wr_evg && bus_wdata[B_FRC];
  assign sts_clr   = wr_sts && !bus_wdata[B_UIF];

  always_comb begin
    cfg_d = cfg_q;
    if (wr_ctl) begin
      cfg_d.cen           = bus_wdata[B_CEN];
      cfg_d.src_wrap_only = bus_wdata[B_SRC];
    end
    if (wr_ien) begin
      cfg_d.uie = bus_wdata[B_UIE];
      cfg_d.ude = bus_wdata[B_UDE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      psc_pend <= '0;
      arl      <= '0;
    end else begin
      cfg_q <= cfg_d;
      if (wr_psc) psc_pend <= bus_wdata[PSC_W-1:0];
      if (wr_arl) arl      <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == ADDR_W'(OFS_CTL)) begin
      rd_val[B_CEN] = cfg_q.cen;
      rd_val[B_SRC] = cfg_q.src_wrap_only;
    end else if (bus_addr == ADDR_W'(OFS_IEN)) begin
      rd_val[B_UIE] = cfg_q.uie;
      rd_val[B_UDE] = cfg_q.ude;
    end else if (bus_addr == ADDR_W'(OFS_STS)) begin
      rd_val[B_UIF] = uif;
    end else if (bus_addr == ADDR_W'(OFS_CNT)) begin
      rd_val[CNT_W-1:0] = cnt_val;
      rd_val[DATA_W-1]  = uif;
    end else if (bus_addr == ADDR_W'(OFS_PSC)) begin
      rd_val[PSC_W-1:0] = psc_pend;
    end else if (bus_addr == ADDR_W'(OFS_ARL)) begin
      rd_val[CNT_W-1:0] = arl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_req) rdata <= rd_val;
    else             rdata <= '0;
  end

endmodule

// File: rtl/updtmr_presc.sv
module updtmr_presc #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cen,
  input  logic             force_upd,
  input  logic             upd,
  input  logic [PSC_W-1:0] psc_pend,
  output logic [PSC_W-1:0] psc_act,
  output logic             tick
);

  logic [PSC_W-1:0] div_q;

  assign tick = cen && !force_upd && (div_q == psc_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      psc_act <= '0;
    end else begin
      if (force_upd)  div_q <= '0;
      else if (tick)  div_q <= '0;
      else if (cen)   div_q <= div_q + 1'b1;
      if (upd) psc_act <= psc_pend;
    end
  end

endmodule

// File: rtl/updtmr_count.sv
module updtmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             force_upd,
  input  logic [CNT_W-1:0] arl,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             upd
);

  assign wrap = tick && (cnt == arl);
  assign upd  = wrap || force_upd;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (force_upd) cnt <= '0;
    else if (wrap)      cnt <= '0;
    else if (tick)      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/updtmr_evt.sv
module updtmr_evt (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic force_upd,
  input  logic src_wrap_only,
  input  logic uie_next,
  input  logic ude,
  input  logic sts_clr,
  output logic uif,
  output logic irq_o,
  output logic dma_o
);

  logic fire, uif_next;

  assign fire = wrap || (force_upd && !src_wrap_only);

  always_comb begin
    uif_next = uif;
    if (sts_clr) uif_next = 1'b0;
    if (fire)    uif_next = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uif   <= 1'b0;
      irq_o <= 1'b0;
      dma_o <= 1'b0;
    end else begin
      uif   <= uif_next;
      irq_o <= uif_next && uie_next;
      dma_o <= fire && ude;
    end
  end

endmodule

// File: rtl/updtmr.sv
module updtmr
  import updtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              dma_o
);

  tmr_cfg_t         cfg_q, cfg_d;
  logic [PSC_W-1:0] psc_pend, psc_act;
  logic [CNT_W-1:0] arl, cnt;
  logic             force_upd, sts_clr, tick, wrap, upd, uif;
  logic             cen_q, src_q, uie_q, ude_q;

  assign cen_q = cfg_q.cen;
  assign src_q = cfg_q.src_wrap_only;
  assign uie_q = cfg_q.uie;
  assign ude_q = cfg_q.ude;

  updtmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt_val(cnt), .uif(uif), .cfg_q(cfg_q), .cfg_d(cfg_d),
    .psc_pend(psc_pend), .arl(arl), .force_upd(force_upd), .sts_clr(sts_clr),
    .rdata(bus_rdata)
  );

  updtmr_presc #(.PSC_W(PSC_W)) u_presc (
    .clk(clk), .rst(rst), .cen(cen_q), .force_upd(force_upd), .upd(upd),
    .psc_pend(psc_pend), .psc_act(psc_act), .tick(tick)
  );

  updtmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .force_upd(force_upd), .arl(arl),
    .cnt(cnt), .wrap(wrap), .upd(upd)
  );

  updtmr_evt u_evt (
    .clk(clk), .rst(rst), .wrap(wrap), .force_upd(force_upd),
    .src_wrap_only(src_q), .uie_next(cfg_d.uie), .ude(ude_q), .sts_clr(sts_clr),
    .uif(uif), .irq_o(irq_o), .dma_o(dma_o)
  );

endmodule

// File: rtl/updtmr_chk.sv
module updtmr_chk #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cen_q,
  input logic             src_q,
  input logic             uie_q,
  input logic             ude_q,
  input logic             tick,
  input logic             wrap,
  input logic             upd,
  input logic             force_upd,
  input logic             sts_clr,
  input logic             uif,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] arl,
  input logic [PSC_W-1:0] psc_act,
  input logic             irq_o,
  input logic             dma_o
);

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == arl && !force_upd) |=> (cnt == '0));

  p_psc_shadow_r3: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(psc_act));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!cen_q && !force_upd) |=> $stable(cnt));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (uif && !sts_clr) |=> uif);

  p_irq_and_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o == (uif && uie_q));

  p_dma_fire_r11: assert property (@(posedge clk) disable iff (rst)
    ((wrap || (force_upd && !src_q)) && ude_q) |=> dma_o);

  p_dma_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !((wrap || (force_upd && !src_q)) && ude_q) |=> !dma_o);

endmodule

bind updtmr updtmr_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst(rst), .cen_q(cen_q), .src_q(src_q), .uie_q(uie_q), .ude_q(ude_q),
  .tick(tick), .wrap(wrap), .upd(upd), .force_upd(force_upd), .sts_clr(sts_clr),
  .uif(uif), .cnt(cnt), .arl(arl), .psc_act(psc_act), .irq_o(irq_o), .dma_o(dma_o)
);

// File: tb/test_updtmr.sv
module test_updtmr;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, dma_o;

  int errs = 0;
  int chks = 0;
  logic last_dma;

  always #4 clk = ~clk;

  updtmr i_updtmr (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .dma_o(dma_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    last_dma = dma_o;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_out(input bit use_dma, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(use_dma ? dma_o : irq_o) && n < 400);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; chks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 dma", {31'b0, dma_o}, 0);
    for (int a = 0; a < 'h30; a += 4) begin
      rd(6'(a), v);
      check("R1 reg reads 0", v, 0);
    end

    // R12 readback of fields
    wr(6'h00, 32'h4); rd(6'h00, v); check("R12 ctl", v, 32'h4);
    wr(6'h00, 32'h0);
    wr(6'h0C, 32'h101); rd(6'h0C, v); check("R12 ien", v, 32'h101);
    wr(6'h0C, 32'h0);
    wr(6'h28, 32'hA5C3); rd(6'h28, v); check("R12 psc", v, 32'hA5C3);
    wr(6'h2C, 32'h5A3C); rd(6'h2C, v); check("R12 arl", v, 32'h5A3C);

    // R2 period sweep, R11 DMA pulse per wrap
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 5; a++) begin
        wr(6'h00, 32'h4);
        wr(6'h28, p);
        wr(6'h2C, a);
        wr(6'h14, 32'h1);
        wr(6'h10, 32'h0);
        wr(6'h0C, 32'h101);
        wr(6'h00, 32'h5);
        wait_out(1'b0, n);
        check("R2 period", n, (a + 1) * (p + 1));
        check("R11 dma at wrap", {31'b0, dma_o}, 1);
        if ((a + 1) * (p + 1) > 1) begin
          @(negedge clk);
          check("R11 dma one cycle", {31'b0, dma_o}, 0);
        end
        wr(6'h00, 32'h4);
      end
    end

    // R3 pending divider
    wr(6'h28, 0);
    wr(6'h2C, 3);
    wr(6'h14, 32'h1);
    wr(6'h28, 3);
    wr(6'h10, 32'h0);
    wr(6'h0C, 32'h100);
    wr(6'h00, 32'h5);
    wait_out(1'b1, n);
    check("R3 old division kept", n, 4);
    wait_out(1'b1, n);
    check("R3 new division after update", n, 16);
    wr(6'h00, 32'h4);

    // R4 hold while disabled, R8 count readback
    wr(6'h28, 0);
    wr(6'h2C, 1000);
    wr(6'h14, 32'h1);
    wr(6'h10, 32'h0);
    wr(6'h0C, 32'h0);
    wr(6'h00, 32'h5);
    repeat (9) @(posedge clk);
    wr(6'h00, 32'h4);
    rd(6'h24, v); check("R8 count value", v, 10);
    repeat (30) @(negedge clk);
    rd(6'h24, v); check("R4 count held", v, 10);

    // R9 limit applies at once
    wr(6'h0C, 32'h1);
    wr(6'h2C, 10);
    wr(6'h00, 32'h5);
    wait_out(1'b0, n);
    check("R9 immediate limit", n, 1);
    wr(6'h00, 32'h4);
    wr(6'h10, 32'h0);

    // R5 forced update with src select 0, R8 mirror, R11 sw DMA
    wr(6'h2C, 1000);
    wr(6'h00, 32'h5);
    repeat (5) @(posedge clk);
    wr(6'h00, 32'h0);
    rd(6'h24, v); check("R5 count nonzero before force", {31'b0, v != 0}, 1);
    wr(6'h0C, 32'h100);
    wr(6'h14, 32'h1);
    check("R11 dma on forced update", {31'b0, last_dma}, 1);
    rd(6'h24, v); check("R8 flag mirror, R5 count zero", v, 32'h8000_0000);
    rd(6'h14, v); check("R5 force bit reads 0", v, 0);
    check("R7 irq low with enable off", {31'b0, irq_o}, 0);
    rd(6'h10, v); check("R6 flag set", v, 1);

    // R7 irq follows enable
    wr(6'h0C, 32'h1);
    check("R7 irq high", {31'b0, irq_o}, 1);

    // R6 write 1 ignored, write 0 clears
    wr(6'h10, 32'h1);
    rd(6'h10, v); check("R6 write 1 no effect", v, 1);
    wr(6'h10, 32'h0);
    rd(6'h10, v); check("R6 cleared", v, 0);
    check("R7 irq low after clear", {31'b0, irq_o}, 0);

    // R10 source select masks forced update
    wr(6'h0C, 32'h101);
    wr(6'h00, 32'h4);
    wr(6'h14, 32'h1);
    check("R10 no dma on masked force", {31'b0, last_dma}, 0);
    rd(6'h10, v); check("R10 no flag on masked force", v, 0);
    check("R10 irq stays low", {31'b0, irq_o}, 0);

    // R11 DMA gated by its enable
    wr(6'h0C, 32'h1);
    wr(6'h00, 32'h0);
    wr(6'h14, 32'h1);
    check("R11 no dma when disabled", {31'b0, last_dma}, 0);
    rd(6'h10, v); check("R6 flag from forced update", v, 1);

    finish_run();
  end

endmodule